// File: doc/BRIEF.md
# Boxcar Mean DC Subtractor

This block takes a stream of unsigned samples, one per clock when the input valid flag is high, and removes their DC content. It estimates the DC level as the plain average of the most recent `WIN` accepted samples and subtracts that estimate from each sample as it passes through. The result leaves the block as a two's-complement value one bit wider than the input, so that swings on both sides of the mean fit.

The average is not built as a wide FIR with one product per tap. A running total gains the newest sample and loses the one leaving a `WIN`-deep circular buffer on each accepted input. Because `WIN` is a power of two, dividing by `WIN` needs only a shift. Idle cycles leave the window untouched. An output is flagged valid only once a full window of history exists. Long windows of a thousand samples or more suit audio and baseband paths whose offset drifts slowly.

Top module: `dc_mean_subtract`

## Requirements
- R1: While reset is low at a rising edge, and after it, until the first valid result, `out_valid` is 0 and `out_sample` is 0.
- R2: For an accepted sample x, `out_sample` equals x (zero-extended) minus floor(S / WIN). S is the sum of the last WIN accepted samples, x included. The result is in `DATA_W+1`-bit two's complement.
- R3: The result for a sample accepted at rising edge k appears on the outputs just after rising edge k+1.
- R4: `out_valid` is 1 for exactly one cycle per accepted sample, and only once at least WIN samples have been accepted since reset, the current one included. For the first WIN-1 samples it stays 0.
- R5: A cycle with `in_valid` low does not change the averaging window, and `out_valid` is 0 in the following cycle.
- R6: A constant input held for at least WIN samples gives an output of 0.
- R7: The running sum never exceeds WIN times the largest input code, whatever the input, and it never wraps.
- R8: `out_sample` keeps its previous value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | DATA_W | Unsigned input sample |
| out_valid | output | 1 | High for one cycle when `out_sample` holds a new result |
| out_sample | output | DATA_W+1 | Signed sample with the window mean removed |

## Verification
The bench builds the block with a 16-bit sample and an 8-sample window. At that size the fill period, the first eviction and many wraps of the circular buffer all fall within a few dozen samples. The full-scale extremes are reachable in eight samples: all-zero history followed by a maximum code, and the reverse. These give the most positive and most negative outputs. Gapped input, a mid-stream reset and a refill are also short enough to run several times each.

// File: rtl/dcsub_pkg.sv
// Shared helpers for the boxcar DC subtractor.
// Assumes window lengths are powers of two and at least 2.
package dcsub_pkg;

    // Shift amount that divides by a power-of-two window length.
    function automatic int unsigned win_shift(input int unsigned win);
        return $clog2(win);
    endfunction

endpackage

// File: rtl/dcsub_ring.sv
// Circular sample buffer of DEPTH entries with one shared pointer.
// Each write returns, on aged_data, the entry being overwritten: the
// sample written DEPTH writes earlier. The contents are not reset; the
// consumer ignores aged_data until DEPTH writes have happened.
module dcsub_ring #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] aged_data
);
    localparam int unsigned PTR_W = dcsub_pkg::win_shift(DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  ptr;

    // Pointer advances once per write and wraps at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (wr_en) ptr <= ptr + 1'b1;
    end

    // Storage array, written in place of the entry being read out.
    always_ff @(posedge clk) begin
        if (wr_en) store[ptr] <= wr_data;
    end

    assign aged_data = store[ptr];

    // R5: the pointer moves on exactly the cycles with a write.
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ptr == ($past(wr_en) ? $past(ptr) + 1'b1 : $past(ptr))));
endmodule

// File: rtl/dcsub_accum.sv
// Running window sum. It adds each new sample and, once the window is
// full, subtracts the aged sample from the ring. It also counts the fill
// level, saturating at DEPTH. Assumes aged_data is the sample written
// DEPTH accepts earlier.
module dcsub_accum #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         add_en,
    input  logic [DATA_W-1:0]                            new_sample,
    input  logic [DATA_W-1:0]                            aged_sample,
    output logic [DATA_W+dcsub_pkg::win_shift(DEPTH)-1:0] sum,
    output logic                                         full_after
);
    localparam int unsigned SH    = dcsub_pkg::win_shift(DEPTH);
    localparam int unsigned ACC_W = DATA_W + SH;
    localparam int unsigned CNT_W = SH + 1;

    logic [CNT_W-1:0]  fill;
    logic              full_now;
    logic [ACC_W-1:0]  evict;

    assign full_now   = (fill == CNT_W'(DEPTH));
    assign evict      = full_now ? ACC_W'(aged_sample) : '0;
    assign full_after = full_now || (fill == CNT_W'(DEPTH - 1));

    // Window sum update: newest in, oldest out.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum <= '0;
        else if (add_en) sum <= sum + ACC_W'(new_sample) - evict;
    end

    // Fill level, saturating once the window holds DEPTH samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fill <= '0;
        else if (add_en && !full_now) fill <= fill + 1'b1;
    end

    // R7: the sum is bounded by fill level times the largest code.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((ACC_W+1)'(sum) <= (ACC_W+1)'(fill) * (ACC_W+1)'({DATA_W{1'b1}})));
endmodule

// File: rtl/dc_mean_subtract.sv
// Streaming DC remover. Stage 1 updates the window sum and delays the
// sample; stage 2 subtracts sum/WIN (a shift) from the delayed sample.
// Assumes WIN is a power of two, at least 2; input is unsigned.
module dc_mean_subtract #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WIN    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [DATA_W:0]   out_sample
);
    localparam int unsigned SH    = dcsub_pkg::win_shift(WIN);
    localparam int unsigned ACC_W = DATA_W + SH;

    logic [DATA_W-1:0] aged;
    logic [ACC_W-1:0]  win_sum;
    logic              full_after;
    logic [DATA_W-1:0] x_dly;
    logic              s1_valid;
    logic              s1_full;
    logic [DATA_W-1:0] mean;

    dcsub_ring #(.DATA_W(DATA_W), .DEPTH(WIN)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_data   (in_sample),
        .aged_data (aged)
    );

    dcsub_accum #(.DATA_W(DATA_W), .DEPTH(WIN)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .add_en      (in_valid),
        .new_sample  (in_sample),
        .aged_sample (aged),
        .sum         (win_sum),
        .full_after  (full_after)
    );

    // Stage 1: hold the sample and its flags in step with the sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_dly    <= '0;
            s1_valid <= 1'b0;
            s1_full  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_full  <= in_valid && full_after;
            if (in_valid) x_dly <= in_sample;
        end
    end

    assign mean = win_sum[ACC_W-1:SH];

    // Stage 2: subtract the mean and publish when the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= s1_valid && s1_full;
            if (s1_valid && s1_full)
                out_sample <= $signed({1'b0, x_dly}) - $signed({1'b0, mean});
        end
    end

    // R4: a valid result always traces back to an accepted sample.
    a_r4_valid_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));
    // R5: an idle stage-1 slot never yields a valid output.
    a_r5_idle_gives_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    // R8: the output value holds while no result is flagged.
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_valid) |-> $stable(out_sample));
endmodule

// File: tb/sim_dc_mean_subtract.sv
module sim_dc_mean_subtract;
    localparam int DW  = 16;
    localparam int WN  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          out_valid;
    logic [DW:0]   out_sample;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dc_mean_subtract #(.DATA_W(DW), .WIN(WN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    // Reference model state
    int hist[$];
    int last_out;
    // two-deep expectation pipe: [0] newest
    bit    e_chk [2];
    bit    e_vld [2];
    int    e_val [2];
    string e_tag [2];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare the outputs with the expectation made two steps earlier.
    task automatic check_oldest();
        if (e_chk[1]) begin
            check(out_valid == e_vld[1], {e_tag[1], " valid"}, out_valid, e_vld[1]);
            if (e_vld[1]) begin
                check($signed(out_sample) == e_val[1], {e_tag[1], " data"},
                      $signed(out_sample), e_val[1]);
                last_out = e_val[1];
            end else begin
                check($signed(out_sample) == last_out, {e_tag[1], " R8 hold"},
                      $signed(out_sample), last_out);
            end
        end
    endtask

    // One clock: check, present inputs, model them, advance.
    task automatic step(input bit v, input int x, input string tag);
        int s;
        check_oldest();
        e_chk[1] = e_chk[0]; e_vld[1] = e_vld[0];
        e_val[1] = e_val[0]; e_tag[1] = e_tag[0];
        in_valid  = v;
        in_sample = DW'(x);
        e_chk[0] = 1; e_tag[0] = tag; e_vld[0] = 0; e_val[0] = 0;
        if (v) begin
            hist.push_back(x);
            if (hist.size() >= WN) begin
                s = 0;
                for (int i = hist.size() - WN; i < hist.size(); i++) s += hist[i];
                e_vld[0] = 1;
                e_val[0] = x - (s >>> 3);
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic flush();
        step(0, 0, "flush R5");
        step(0, 0, "flush R5");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(out_valid == 0, "R1 valid after reset", out_valid, 0);
        check(out_sample == 0, "R1 data after reset", $signed(out_sample), 0);
        rst_n = 1;
        hist.delete();
        last_out = 0;
        for (int i = 0; i < 2; i++) e_chk[i] = 0;
    endtask

    task automatic t_fill_constant();
        for (int i = 0; i < WN - 1; i++) step(1, 1000, "R4 filling");
        for (int i = 0; i < 6; i++) step(1, 1000, "R6 constant");
        flush();
    endtask

    task automatic t_pattern();
        for (int i = 0; i < 30; i++) step(1, (i * 7919 + 123) & 16'hFFFF, "R2 pattern");
        flush();
    endtask

    task automatic t_latency();
        step(0, 0, "R3 idle");
        step(1, 40000, "R3 single");
        step(0, 0, "R3 after");
        flush();
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 20; i++) begin
            step(1, 3000 + i * 1500, "R5 gapped");
            step(0, 65535, "R5 idle");
        end
        flush();
    endtask

    task automatic t_extremes();
        for (int i = 0; i < WN; i++) step(1, 0, "R7 zeros");
        step(1, 65535, "R7 max positive");
        for (int i = 0; i < 2 * WN; i++) step(1, 65535, "R7 full scale");
        step(1, 0, "R7 max negative");
        flush();
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 5; i++) step(1, 50000, "R4 pre reset");
        do_reset();
        for (int i = 0; i < WN + 3; i++) step(1, 200 + i, "R4 refill");
        flush();
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin e_chk[i] = 0; e_tag[i] = ""; end
        last_out = 0;
        do_reset();
        t_fill_constant();
        t_pattern();
        t_latency();
        t_gaps();
        t_extremes();
        t_midreset();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_run++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule